// File: doc/BRIEF.md
# Ping-Pong PCM Playback Controller

This block plays PCM audio from a memory buffer that is split into two equal halves. Software sets a base address, a size and a sample format through a small 32-bit register port, then turns playback on. The block reads one half, sends it to a stereo sink as 16-bit left/right frames, and marks that half as consumed in a status register. It then moves on to the other half. Software refills the half that has just been played while the other one is being read, and it is told when to do so by a level interrupt.

Samples can be 8 or 16 bits wide, mono or stereo, which gives four formats. The block does not start a half until the sink reports room for every frame of that half. It also computes the bit-clock setting, which is a master-clock choice plus a divide ratio, for a codec interface outside this block.

Top module: `pcm_pingpong_player`

## Requirements
- R1: After reset the mode, status and interrupt-enable registers read 0, the position reads 0, and `irq`, `mem_req` and `smp_valid` are low.
- R2: Mode bit 0 selects the sample width. When it is 1, samples are 16-bit little-endian: the byte at the lower address goes to bits 7:0. When it is 0, samples are signed 8-bit values taken from `mem_rdata[7:0]` and multiplied by 256, so the byte moves to the high byte and the low byte is zero; `mem_rdata[15:8]` is ignored. When mode bit 14 is 1 (mono), each sample goes to both channels. In stereo the left sample comes from the lower address and the right sample follows it.
- R3: The threshold register holds a value v. The buffer then spans 4·(v+1) bytes and each half spans 2·(v+1) bytes. A half yields (half bytes) / (bytes per frame) frames, rounded down. A half is started only when `sink_room` is at least that frame count.
- R4: When the half at position 0 has been consumed, status bit 6 is set and the position becomes the half size. When the other half has been consumed, status bit 7 is set and the position returns to 0. Each sample is read from base + position + its offset within the half.
- R5: Writing the status register clears each bit written as 1. If a clear and a set of the same bit fall in the same cycle, the set wins.
- R6: `irq` is high exactly when status bits 7:6 AND enable bits 7:6 is nonzero. It follows a write to the enable register in the next cycle.
- R7: A write that changes mode bit 7 (run) from 0 to 1 clears the status register and the position.
- R8: Writing the base-low, base-high or divider register sets the position to 0 and abandons the half in progress. Playback then resumes from the new base.
- R9: `mclk_fast` equals mode bit 9 (1 selects the faster master clock). `bclk_ratio` equals 64·(divider bits 15:8 + 1).
- R10: The register offsets are: mode 0x00, divider 0x18, status 0x20, enable 0x24, base low 0x28, threshold 0x2C, position 0x38 (read-only, returns the position shifted right by 2), base high 0x40. Mode, divider, status and enable read back. Threshold, base and all unmapped offsets read 0.
- R11: While run is 0, no memory read is requested and no frame is offered, starting two cycles after run falls.
- R12: A frame offered with `smp_valid` high stays unchanged until `smp_ready` accepts it, unless playback is stopped or restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the sample |
| mem_wide | output | 1 | 1: 16-bit read, 0: byte read |
| mem_ack | input | 1 | Read completes in this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| sink_room | input | THR_W+2 | Frames the sink can accept now |
| smp_valid | output | 1 | Stereo frame offered |
| smp_ready | input | 1 | Sink accepts the frame |
| smp_left | output | 16 | Left sample |
| smp_right | output | 16 | Right sample |
| mclk_fast | output | 1 | Master clock select for the bit clock |
| bclk_ratio | output | 15 | Master-to-bit-clock divide ratio |
| irq | output | 1 | Level interrupt |

## Verification
Two events can land in the same clock edge. One is the engine finishing a half, which sets a status bit. The other is a software write-1-to-clear of that same bit. To force them together, the bench keeps writing 0x40 to the status register, with bit 6 enabled as an interrupt, for every cycle until a half completes. If the set wins, `irq` goes high for exactly one cycle. If the clear wins, `irq` never rises. A second pairing is a restart write that arrives while a frame is stalled in the handshake: the bench checks that playback resumes from position 0 at the new base.

// File: rtl/pcm_pp_pkg.sv
package pcm_pp_pkg;

  localparam int ADDR_W = 32;

  // register offsets
  localparam logic [7:0] OFS_MODE    = 8'h00;
  localparam logic [7:0] OFS_DIV     = 8'h18;
  localparam logic [7:0] OFS_STAT    = 8'h20;
  localparam logic [7:0] OFS_IEN     = 8'h24;
  localparam logic [7:0] OFS_BASE_LO = 8'h28;
  localparam logic [7:0] OFS_THR     = 8'h2C;
  localparam logic [7:0] OFS_POS     = 8'h38;
  localparam logic [7:0] OFS_BASE_HI = 8'h40;

  // mode bits
  localparam int MB_WIDE = 0;
  localparam int MB_RUN  = 7;
  localparam int MB_MCLK = 9;
  localparam int MB_MONO = 14;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_FETCH,
    ENG_SEND,
    ENG_DONE
  } eng_state_t;

  // log2 of bytes per frame
  function automatic logic [1:0] frame_shift(input logic wide, input logic mono);
    return {1'b0, wide} + {1'b0, ~mono};
  endfunction

  // raw memory data to a 16-bit sample
  function automatic logic [15:0] widen(input logic wide, input logic [15:0] raw);
    return wide ? raw : {raw[7:0], 8'h00};
  endfunction

  // master clock cycles per bit clock
  function automatic logic [14:0] bclk_ratio_f(input logic [7:0] d);
    return ({7'd0, d} + 15'd1) << 6;
  endfunction

endpackage

// File: rtl/pcm_pp_regs.sv
module pcm_pp_regs
  import pcm_pp_pkg::*;
#(
  parameter int THR_W = 16,
  localparam int POS_W = THR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              set_half,
  input  logic              set_full,
  input  logic [POS_W-1:0]  pos_q,
  output logic [31:0]       mode_q,
  output logic [31:0]       div_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [POS_W-1:0]  half_bytes,
  output logic [1:0]        stat_q,
  output logic [31:0]       ien_q,
  output logic              restart,
  output logic              irq
);

  logic [THR_W-1:0] thr_q;
  logic             wr_mode, wr_div, wr_stat, wr_ien, wr_lo, wr_hi, wr_thr;
  logic             run_rise;
  logic [1:0]       stat_d;

  assign wr_mode = reg_wr && (reg_addr == OFS_MODE);
  assign wr_div  = reg_wr && (reg_addr == OFS_DIV);
  assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
  assign wr_ien  = reg_wr && (reg_addr == OFS_IEN);
  assign wr_lo   = reg_wr && (reg_addr == OFS_BASE_LO);
  assign wr_hi   = reg_wr && (reg_addr == OFS_BASE_HI);
  assign wr_thr  = reg_wr && (reg_addr == OFS_THR);

  assign run_rise = wr_mode && reg_wdata[MB_RUN] && !mode_q[MB_RUN];
  assign restart  = run_rise || wr_lo || wr_hi || wr_div;

  assign half_bytes = ({2'b00, thr_q} + POS_W'(1)) << 1;

  // event sets win over software clears
  always_comb begin
    stat_d = stat_q;
    if (wr_stat) stat_d = stat_d & ~reg_wdata[7:6];
    if (run_rise) stat_d = 2'b00;
    stat_d = stat_d | {set_full, set_half};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= '0;
      base_q <= '0;
      thr_q  <= '0;
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_div)  div_q  <= reg_wdata;
      if (wr_ien)  ien_q  <= reg_wdata;
      if (wr_thr)  thr_q  <= reg_wdata[THR_W-1:0];
      if (wr_lo)   base_q[15:0]  <= reg_wdata[15:0];
      if (wr_hi)   base_q[31:16] <= reg_wdata[15:0];
    end
  end

  assign irq = |(stat_q & ien_q[7:6]);

  always_comb begin
    case (reg_addr)
      OFS_MODE: reg_rdata = mode_q;
      OFS_DIV:  reg_rdata = div_q;
      OFS_STAT: reg_rdata = {24'd0, stat_q, 6'd0};
      OFS_IEN:  reg_rdata = ien_q;
      OFS_POS:  reg_rdata = 32'(pos_q >> 2);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pcm_pp_engine.sv
module pcm_pp_engine
  import pcm_pp_pkg::*;
#(
  parameter int POS_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              wide,
  input  logic              mono,
  input  logic [ADDR_W-1:0] base,
  input  logic [POS_W-1:0]  half_bytes,
  input  logic [POS_W-1:0]  sink_room,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wide,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [15:0]       smp_left,
  output logic [15:0]       smp_right,
  output logic [POS_W-1:0]  pos_q,
  output logic              set_half,
  output logic              set_full
);

  eng_state_t       st_q;
  logic [POS_W-1:0] boff_q, fcnt_q, fpb, step;
  logic             samp_q;
  logic [15:0]      left_q, right_q, smp_now;
  logic             room_ok, last_frame;

  assign fpb        = half_bytes >> frame_shift(wide, mono);
  assign step       = wide ? POS_W'(2) : POS_W'(1);
  assign room_ok    = sink_room >= fpb;
  assign last_frame = (fcnt_q + POS_W'(1)) == fpb;
  assign smp_now    = widen(wide, mem_rdata);

  assign mem_req   = (st_q == ENG_FETCH);
  assign mem_wide  = wide;
  assign mem_addr  = base + ADDR_W'(pos_q) + ADDR_W'(boff_q);
  assign smp_valid = (st_q == ENG_SEND);
  assign smp_left  = left_q;
  assign smp_right = right_q;

  assign set_half = (st_q == ENG_DONE) && run && !restart && (pos_q == '0);
  assign set_full = (st_q == ENG_DONE) && run && !restart && (pos_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      pos_q   <= '0;
      boff_q  <= '0;
      fcnt_q  <= '0;
      samp_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else if (restart || !run) begin
      st_q   <= ENG_IDLE;
      boff_q <= '0;
      fcnt_q <= '0;
      samp_q <= 1'b0;
      if (restart) pos_q <= '0;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          boff_q <= '0;
          fcnt_q <= '0;
          samp_q <= 1'b0;
          if (room_ok) st_q <= (fpb == '0) ? ENG_DONE : ENG_FETCH;
        end
        ENG_FETCH: begin
          if (mem_ack) begin
            boff_q <= boff_q + step;
            if (!samp_q) begin
              left_q <= smp_now;
              if (mono) begin
                right_q <= smp_now;
                st_q    <= ENG_SEND;
              end else begin
                samp_q <= 1'b1;
              end
            end else begin
              right_q <= smp_now;
              samp_q  <= 1'b0;
              st_q    <= ENG_SEND;
            end
          end
        end
        ENG_SEND: begin
          if (smp_ready) begin
            fcnt_q <= fcnt_q + POS_W'(1);
            st_q   <= last_frame ? ENG_DONE : ENG_FETCH;
          end
        end
        ENG_DONE: begin
          pos_q <= (pos_q == '0) ? half_bytes : '0;
          st_q  <= ENG_IDLE;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pcm_pingpong_player.sv
module pcm_pingpong_player
  import pcm_pp_pkg::*;
#(
  parameter int THR_W = 16,
  localparam int POS_W = THR_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  output logic             mem_wide,
  input  logic             mem_ack,
  input  logic [15:0]      mem_rdata,
  input  logic [POS_W-1:0] sink_room,
  output logic             smp_valid,
  input  logic             smp_ready,
  output logic [15:0]      smp_left,
  output logic [15:0]      smp_right,
  output logic             mclk_fast,
  output logic [14:0]      bclk_ratio,
  output logic             irq
);

  logic [31:0]       mode_q, div_q, ien_q;
  logic [ADDR_W-1:0] base_q;
  logic [POS_W-1:0]  half_bytes, pos_q;
  logic [1:0]        stat_q;
  logic              restart_w, set_half, set_full;
  logic              run_w, wide_w, mono_w;

  assign run_w  = mode_q[MB_RUN];
  assign wide_w = mode_q[MB_WIDE];
  assign mono_w = mode_q[MB_MONO];

  pcm_pp_regs #(.THR_W(THR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .set_half   (set_half),
    .set_full   (set_full),
    .pos_q      (pos_q),
    .mode_q     (mode_q),
    .div_q      (div_q),
    .base_q     (base_q),
    .half_bytes (half_bytes),
    .stat_q     (stat_q),
    .ien_q      (ien_q),
    .restart    (restart_w),
    .irq        (irq)
  );

  pcm_pp_engine #(.POS_W(POS_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_w),
    .restart    (restart_w),
    .wide       (wide_w),
    .mono       (mono_w),
    .base       (base_q),
    .half_bytes (half_bytes),
    .sink_room  (sink_room),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_wide   (mem_wide),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .pos_q      (pos_q),
    .set_half   (set_half),
    .set_full   (set_full)
  );

  assign mclk_fast  = mode_q[MB_MCLK];
  assign bclk_ratio = bclk_ratio_f(div_q[15:8]);

endmodule

// File: rtl/pcm_pp_checker.sv
module pcm_pp_checker
  import pcm_pp_pkg::*;
#(
  parameter int POS_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             restart,
  input logic             reg_wr,
  input logic [7:0]       reg_addr,
  input logic [1:0]       wd76,
  input logic [1:0]       stat_q,
  input logic [1:0]       ien76,
  input logic             irq,
  input logic             mem_req,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic [15:0]      smp_left,
  input logic [15:0]      smp_right,
  input logic [POS_W-1:0] pos_q,
  input logic [POS_W-1:0] half_bytes,
  input logic             set_half
);

  a_r4_half_marks_bit6: assert property (@(posedge clk) disable iff (!rst_n)
    set_half |=> (stat_q[0] && pos_q == $past(half_bytes)));

  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_STAT && wd76[0] && !set_half) |=> !stat_q[0]);

  a_r6_enable_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_IEN && (wd76 & stat_q) != 2'b00) |=> irq);

  a_r7_run_rise_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (stat_q == 2'b00 && pos_q == '0));

  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> (!mem_req && !smp_valid));

  a_r12_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && run && !restart) |=>
      (smp_valid && $stable(smp_left) && $stable(smp_right)));

  a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (stat_q != 2'b00 && ien76 != 2'b00));

endmodule

bind pcm_pingpong_player pcm_pp_checker #(.POS_W(POS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run_w),
  .restart    (restart_w),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .wd76       (reg_wdata[7:6]),
  .stat_q     (stat_q),
  .ien76      (ien_q[7:6]),
  .irq        (irq),
  .mem_req    (mem_req),
  .smp_valid  (smp_valid),
  .smp_ready  (smp_ready),
  .smp_left   (smp_left),
  .smp_right  (smp_right),
  .pos_q      (pos_q),
  .half_bytes (half_bytes),
  .set_half   (set_half)
);

// File: tb/tb_pcm_pingpong_player.sv
module tb_pcm_pingpong_player;

  localparam int CLK_PERIOD = 10;
  localparam int THR_W = 16;
  localparam int POS_W = THR_W + 2;
  localparam int WD_CYCLES = 150000;

  localparam logic [7:0] A_MODE = 8'h00, A_DIV = 8'h18, A_STAT = 8'h20, A_IEN = 8'h24,
                         A_LO = 8'h28, A_THR = 8'h2C, A_POS = 8'h38, A_HI = 8'h40;
  localparam logic [31:0] RUN = 32'h80, WIDE = 32'h1, MONO = 32'h4000, FAST = 32'h200;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             reg_wr = 0;
  logic [7:0]       reg_addr = 0;
  logic [31:0]      reg_wdata = 0;
  logic [31:0]      reg_rdata;
  logic             mem_req, mem_wide;
  logic [31:0]      mem_addr;
  logic             mem_ack = 0;
  logic [15:0]      mem_rdata = 0;
  logic [POS_W-1:0] sink_room = '1;
  logic             smp_valid;
  logic             smp_ready = 0;
  logic [15:0]      smp_left, smp_right;
  logic             mclk_fast;
  logic [14:0]      bclk_ratio;
  logic             irq;

  pcm_pingpong_player #(.THR_W(THR_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  int blocks_done = 0, stop_at = -1, fidx = 0;
  int mem_txn = 0, req_seen = 0, valid_seen = 0;
  bit rdy_en = 0;
  logic [31:0] exp_base = 0;
  bit exp_wide = 0, exp_mono = 0;
  int exp_half = 2, exp_pos = 0;
  int mon_bpf, mon_fpb;
  logic [31:0] mon_addr, mon_want;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] exp_frame(input logic [31:0] a, input bit wide, input bit mono);
    logic [15:0] l, r;
    if (wide) begin
      l = {mb(a + 1), mb(a)};
      r = mono ? l : {mb(a + 3), mb(a + 2)};
    end else begin
      l = 16'($signed(mb(a)) * 256);
      r = mono ? l : 16'($signed(mb(a + 1)) * 256);
    end
    return {l, r};
  endfunction

  // memory model, sink model and frame checker
  always @(negedge clk) begin
    if (!rst_n) begin
      smp_ready = 0;
      mem_ack = 0;
    end else begin
      smp_ready = rdy_en && ($urandom_range(3) != 0);
      mem_ack = mem_req && ($urandom_range(2) != 0);
      mem_rdata = mem_wide ? {mb(mem_addr + 1), mb(mem_addr)} : {8'($urandom), mb(mem_addr)};
      if (mem_req) req_seen++;
      if (mem_req && mem_ack) mem_txn++;
      if (smp_valid) valid_seen++;
      if (smp_valid && smp_ready) begin
        mon_bpf = (exp_wide ? 2 : 1) * (exp_mono ? 1 : 2);
        mon_fpb = exp_half / mon_bpf;
        mon_addr = exp_base + 32'(exp_pos) + 32'(fidx * mon_bpf);
        mon_want = exp_frame(mon_addr, exp_wide, exp_mono);
        chk({smp_left, smp_right} == mon_want, "R2 R4 frame", {smp_left, smp_right}, mon_want);
        fidx++;
        if (fidx >= mon_fpb) begin
          fidx = 0;
          exp_pos = (exp_pos == 0) ? exp_half : 0;
          blocks_done++;
          if (blocks_done == stop_at) rdy_en = 0;
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_blocks(input int target, input string req);
    int n = 0;
    while (blocks_done < target && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(blocks_done >= target, req, 32'(blocks_done), 32'(target));
  endtask

  task automatic setup(input logic [31:0] base, input int thr, input bit wide, input bit mono);
    wr(A_MODE, 0);
    exp_base = base; exp_wide = wide; exp_mono = mono;
    exp_half = (thr + 1) * 2; exp_pos = 0; fidx = 0;
    wr(A_LO, {16'd0, base[15:0]});
    wr(A_HI, {16'd0, base[31:16]});
    wr(A_THR, 32'(thr));
  endtask

  task automatic play(input logic [31:0] base, input int thr, input bit wide, input bit mono, input int nblk);
    logic [31:0] v;
    setup(base, thr, wide, mono);
    stop_at = blocks_done + nblk;
    rdy_en = 1;
    wr(A_MODE, RUN | (wide ? WIDE : 0) | (mono ? MONO : 0));
    wait_blocks(stop_at, "R4 blocks");
    repeat (6) @(negedge clk);
    rd(A_STAT, v);
    chk(v == ((nblk >= 2) ? 32'hC0 : 32'h40), "R4 status", v, (nblk >= 2) ? 32'hC0 : 32'h40);
    rd(A_POS, v);
    chk(v == 32'(exp_pos >> 2), "R10 position", v, 32'(exp_pos >> 2));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R1 actual %0d cycles expected fewer", WD_CYCLES);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt, s0, s1, g;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_MODE, v); chk(v == 0, "R1 mode", v, 0);
    rd(A_STAT, v); chk(v == 0, "R1 status", v, 0);
    rd(A_IEN, v);  chk(v == 0, "R1 enable", v, 0);
    rd(A_POS, v);  chk(v == 0, "R1 position", v, 0);
    chk({irq, mem_req, smp_valid} == 0, "R1 outputs", {29'd0, irq, mem_req, smp_valid}, 0);

    // R9 bit clock setting
    for (int i = 0; i < 4; i++) begin
      logic [7:0] d;
      bit f;
      d = (i == 0) ? 8'hFF : 8'($urandom);
      f = i[0];
      wr(A_DIV, {16'd0, d, 8'($urandom)});
      wr(A_MODE, f ? FAST : 0);
      chk(mclk_fast == f, "R9 master select", {31'd0, mclk_fast}, {31'd0, f});
      chk(bclk_ratio == 15'((int'(d) + 1) * 64), "R9 ratio", {17'd0, bclk_ratio}, 32'((int'(d) + 1) * 64));
      rd(A_DIV, v);
      chk(v[15:8] == d, "R10 divider readback", {24'd0, v[15:8]}, {24'd0, d});
    end

    // R10 write-only and unmapped offsets
    wr(A_THR, 32'h1234);
    rd(A_THR, v);   chk(v == 0, "R10 threshold reads 0", v, 0);
    rd(8'h04, v);   chk(v == 0, "R10 unmapped 0x04", v, 0);
    rd(8'h3C, v);   chk(v == 0, "R10 unmapped 0x3C", v, 0);

    // R2 R3 R4 all four formats, directed
    play(32'h0001_0000, 7, 0, 0, 2);
    play(32'h0002_0103, 7, 0, 1, 2);
    play(32'h0003_0200, 7, 1, 1, 2);
    play(32'h0004_0300, 2, 1, 0, 2);   // R3 odd leftover: 6-byte half, one frame
    // random formats and sizes
    for (int i = 0; i < 4; i++)
      play($urandom, 1 + $urandom_range(14), 1'($urandom), 1'($urandom), 2);

    // R6 interrupt follows enable writes (status holds 0xC0)
    wr(A_IEN, 0);
    chk(irq == 0, "R6 masked", {31'd0, irq}, 0);
    wr(A_IEN, 32'h80);
    chk(irq == 1, "R6 enable raises", {31'd0, irq}, 1);
    wr(A_STAT, 32'h80);
    chk(irq == 0, "R6 cleared cause", {31'd0, irq}, 0);
    rd(A_STAT, v);
    chk(v == 32'h40, "R5 only bit7 cleared", v, 32'h40);

    // R7 run rising edge clears status and position
    wr(A_MODE, 0);
    wr(A_MODE, RUN);
    rd(A_STAT, v); chk(v == 0, "R7 status cleared", v, 0);
    rd(A_POS, v);  chk(v == 0, "R7 position cleared", v, 0);

    // R8 restart writes mid-playback
    play(32'h0005_0000, 15, 0, 0, 1);
    rd(A_POS, v);  chk(v == 8, "R8 parked in second half", v, 8);
    exp_base = 32'h0005_0440; exp_pos = 0; fidx = 0;
    wr(A_LO, 32'h0440);
    rd(A_POS, v);  chk(v == 0, "R8 base write resets position", v, 0);
    stop_at = blocks_done + 1; rdy_en = 1;
    wait_blocks(stop_at, "R8 resume after base write");
    repeat (6) @(negedge clk);
    rd(A_POS, v);  chk(v == 8, "R8 position after resume", v, 8);
    exp_pos = 0; fidx = 0;
    wr(A_DIV, 32'h0300);
    rd(A_POS, v);  chk(v == 0, "R8 divider write resets position", v, 0);
    stop_at = blocks_done + 1; rdy_en = 1;
    wait_blocks(stop_at, "R8 resume after divider write");

    // R3 room gating
    setup(32'h0006_0000, 7, 0, 1);   // 16 frames per half
    sink_room = 15;
    s0 = mem_txn;
    stop_at = blocks_done + 1; rdy_en = 1;
    wr(A_MODE, RUN | MONO);
    repeat (40) @(negedge clk);
    chk(mem_txn == s0, "R3 no fetch without room", 32'(mem_txn - s0), 0);
    sink_room = 16;
    wait_blocks(stop_at, "R3 starts with room");
    sink_room = '1;

    // R5 set and clear of bit 6 in the same cycle
    setup(32'h0007_0000, 7, 0, 1);
    wr(A_IEN, 32'h40);
    wr(A_STAT, 32'hC0);
    stop_at = blocks_done + 1; rdy_en = 1;
    wr(A_MODE, RUN | MONO);
    s0 = blocks_done;
    @(negedge clk);
    reg_wr = 1; reg_addr = A_STAT; reg_wdata = 32'h40;
    cnt = 0; g = 0;
    while (blocks_done == s0 && g < 20000) begin
      @(negedge clk);
      if (irq) cnt++;
      g++;
    end
    repeat (4) begin
      @(negedge clk);
      if (irq) cnt++;
    end
    reg_wr = 0;
    chk(cnt == 1, "R5 set wins for one cycle", 32'(cnt), 1);
    @(negedge clk);
    rd(A_STAT, v); chk(v == 0, "R5 cleared afterwards", v, 0);

    // R11 and R12: stop mid-stream, nothing moves afterwards
    rdy_en = 1; stop_at = -1;
    repeat (20) @(negedge clk);
    wr(A_MODE, 0);
    rdy_en = 0;
    @(negedge clk);
    s0 = req_seen; s1 = valid_seen;
    repeat (30) @(negedge clk);
    chk(req_seen == s0, "R11 no requests when stopped", 32'(req_seen - s0), 0);
    chk(valid_seen == s1, "R11 no frames when stopped", 32'(valid_seen - s1), 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule